// File: doc/BRIEF.md
# Ten-bit-address I2C slave receiver

This block is an I2C slave that only receives. It accepts master-write transfers whose target is a 10-bit address. The address arrives as two bytes. The first is the high byte, with the fixed pattern `11110`, address bits 9 and 8, and a clear R/W bit. The second is the low byte, carrying address bits 7 to 0. One software-writable compare register holds whichever address byte is expected next. Between the two bytes, the block holds SCL low and raises an update-address flag. Software then swaps the register contents, and that write releases the clock.

After both address bytes have matched, every data byte is acknowledged and placed in a one-byte receive buffer, and the interrupt flag is raised. Software reads the buffer through a strobe. An optional clock-stretch mode holds SCL low after each data byte until software sets a release bit. A data byte that arrives while the buffer is still full is refused with a NACK and flagged as an overflow. A Stop condition returns the block to idle.

The bus lines enter through synchronizer chains. The block drives the bus only through active-high pull-low enables, and an external open-drain stage realises them.

Top module: `i2c_tenbit_rx`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) sets `start_seen_o`. It raises `irq_o` only when `start_irq_en_i` is 1.
- R2: The first byte after Start must equal the compare register, have bits [7:3] = 11110 and have bit 0 = 0. On a match the block pulls SDA low for the 9th clock, loads the byte into the buffer and sets `buf_full_o`, `upd_addr_o` and `irq_o`. Otherwise it lets SDA float (NACK), sets no flag and ignores the bus until the next Start.
- R3: After an acknowledged address byte, `scl_pull_o` stays 1 until an accepted compare-register write. That write also clears `upd_addr_o`.
- R4: The second byte is compared with the compare register as a whole. On a match the block gives ACK, loads the buffer and sets `buf_full_o`, `upd_addr_o` and `irq_o`.
- R5: A second byte that does not match gets a NACK. It still sets `upd_addr_o` and `irq_o`, leaves `buf_full_o` clear and leaves `rel_o` unchanged. Later bytes are refused until the next Start.
- R6: A compare-register write is ignored while an address byte is in progress, from its first bit until the end of its acknowledge clock.
- R7: Each data byte after a full address match gets an ACK on the 9th clock, is loaded into `rxbuf_o`, and sets `buf_full_o` and `irq_o`.
- R8: With `stretch_en_i` = 1, each received data byte clears `rel_o` and holds SCL low until `rel_set_i` is pulsed.
- R9: Only the `rxbuf_rd_i` strobe clears `buf_full_o`.
- R10: A Stop condition (SDA rising while SCL is high) clears `start_seen_o` and returns the block to idle, so bytes clocked without a new Start get a NACK and load nothing.
- R11: A data byte that arrives while `buf_full_o` = 1 gets a NACK, leaves `rxbuf_o` unchanged and sets `ovf_o` and `irq_o`. `irq_clr_i` clears both `irq_o` and `ovf_o`.
- R12: SDA is sampled on each SCL rising edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_pull_o | output | 1 | Pull SCL low (clock hold) |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| addr_wr_i | input | 1 | Write strobe for the compare register |
| addr_wdata_i | input | 8 | Value written to the compare register |
| addr_q_o | output | 8 | Current compare register contents |
| rxbuf_o | output | 8 | Receive buffer |
| rxbuf_rd_i | input | 1 | Buffer read strobe |
| start_seen_o | output | 1 | Start detected since the last Stop |
| upd_addr_o | output | 1 | Compare register must be reloaded |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| irq_o | output | 1 | Interrupt flag |
| ovf_o | output | 1 | Data byte refused because the buffer was full |
| irq_clr_i | input | 1 | Clears `irq_o` and `ovf_o` |
| rel_o | output | 1 | Clock-release bit (0 = SCL held) |
| rel_set_i | input | 1 | Sets the release bit |
| stretch_en_i | input | 1 | Hold SCL after each data byte |
| start_irq_en_i | input | 1 | Raise the interrupt on Start |

## Verification
The hardest state to reach is a mid-byte write to the compare register, because the bus master and the software side are normally strictly sequential. The bench's byte task therefore issues a register write between two bits of the high address byte, and the bench then reads the register back to confirm the write was dropped. The low-byte mismatch path is also hard to reach, because it needs a fully acknowledged high byte and a clock hold before it. It is reached by a complete swap followed by a wrong low byte, and the bench then confirms that the following bytes are refused. An overflow comes from clocking a second data byte with the buffer deliberately left unread.

// File: rtl/i2c_tenbit_pkg.sv
package i2c_tenbit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [4:0] HI_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_DATA,
        ST_SKIP
    } rx_st_e;

    typedef struct packed {
        rx_st_e             st;
        logic [CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               ack;
        logic [BYTE_W-1:0]  cmp;
        logic [BYTE_W-1:0]  rxbuf;
        logic               start_seen;
        logic               ua;
        logic               bf;
        logic               irq;
        logic               ovf;
        logic               rel;
    } rx_state_t;
endpackage

// File: rtl/i2c_tenbit_sync.sv
module i2c_tenbit_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_tenbit_cond.sv
module i2c_tenbit_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tenbit_rx.sv
module i2c_tenbit_rx
    import i2c_tenbit_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ADDR_RST    = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    input  logic       addr_wr_i,
    input  logic [7:0] addr_wdata_i,
    output logic [7:0] addr_q_o,
    output logic [7:0] rxbuf_o,
    input  logic       rxbuf_rd_i,
    output logic       start_seen_o,
    output logic       upd_addr_o,
    output logic       buf_full_o,
    output logic       irq_o,
    output logic       ovf_o,
    input  logic       irq_clr_i,
    output logic       rel_o,
    input  logic       rel_set_i,
    input  logic       stretch_en_i,
    input  logic       start_irq_en_i
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_CLK  = CNT_W'(BYTE_W + 1);

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       byte_ok, wr_ok;
    rx_state_t  q, d;

    i2c_tenbit_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(line_s)
    );

    i2c_tenbit_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    always_comb begin
        case (q.st)
            ST_HI:   byte_ok = (q.shreg == q.cmp) && (q.shreg[7:3] == HI_TAG) && !q.shreg[0];
            ST_LO:   byte_ok = (q.shreg == q.cmp);
            ST_DATA: byte_ok = !q.bf;
            default: byte_ok = 1'b0;
        endcase
    end

    assign wr_ok = !(((q.st == ST_HI) || (q.st == ST_LO)) && (q.bit_cnt != '0));

    always_comb begin
        d = q;
        // software side
        if (rxbuf_rd_i) d.bf = 1'b0;
        if (irq_clr_i) begin
            d.irq = 1'b0;
            d.ovf = 1'b0;
        end
        if (rel_set_i) d.rel = 1'b1;
        if (addr_wr_i && wr_ok) begin
            d.cmp = addr_wdata_i;
            d.ua  = 1'b0;
        end
        // bus side
        if (start_det) begin
            d.st         = ST_HI;
            d.bit_cnt    = '0;
            d.ack        = 1'b0;
            d.start_seen = 1'b1;
            if (start_irq_en_i) d.irq = 1'b1;
        end else if (stop_det) begin
            d.st         = ST_IDLE;
            d.bit_cnt    = '0;
            d.ack        = 1'b0;
            d.start_seen = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise && q.bit_cnt < LAST_BIT) begin
                d.shreg   = {q.shreg[BYTE_W-2:0], line_s[0]};
                d.bit_cnt = q.bit_cnt + 1'b1;
            end else if (scl_rise && q.bit_cnt == LAST_BIT) begin
                d.bit_cnt = ACK_CLK;
            end else if (scl_fall && q.bit_cnt == LAST_BIT) begin
                d.ack = byte_ok;
            end else if (scl_fall && q.bit_cnt == ACK_CLK) begin
                d.ack     = 1'b0;
                d.bit_cnt = '0;
                case (q.st)
                    ST_HI: begin
                        if (q.ack) begin
                            d.ua    = 1'b1;
                            d.irq   = 1'b1;
                            d.bf    = 1'b1;
                            d.rxbuf = q.shreg;
                            d.st    = ST_LO;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_LO: begin
                        d.ua  = 1'b1;
                        d.irq = 1'b1;
                        if (q.ack) begin
                            d.bf    = 1'b1;
                            d.rxbuf = q.shreg;
                            d.st    = ST_DATA;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_DATA: begin
                        d.irq = 1'b1;
                        if (q.ack) begin
                            d.bf    = 1'b1;
                            d.rxbuf = q.shreg;
                            if (stretch_en_i) d.rel = 1'b0;
                        end else begin
                            d.ovf = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= ST_IDLE;
            q.cmp        <= ADDR_RST;
            q.rel        <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_pull_o   = (q.ua | ~q.rel) & (q.st != ST_IDLE);
    assign sda_pull_o   = q.ack;
    assign addr_q_o     = q.cmp;
    assign rxbuf_o      = q.rxbuf;
    assign start_seen_o = q.start_seen;
    assign upd_addr_o   = q.ua;
    assign buf_full_o   = q.bf;
    assign irq_o        = q.irq;
    assign ovf_o        = q.ovf;
    assign rel_o        = q.rel;
endmodule

// File: rtl/i2c_tenbit_rx_chk.sv
module i2c_tenbit_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_pull_o,
    input logic       sda_pull_o,
    input logic       addr_wr_i,
    input logic [7:0] addr_q_o,
    input logic [7:0] rxbuf_o,
    input logic       rxbuf_rd_i,
    input logic       upd_addr_o,
    input logic       buf_full_o,
    input logic       irq_o,
    input logic       ovf_o,
    input logic       rel_o,
    input logic       rel_set_i,
    input logic       stretch_en_i
);
    assert_hold_until_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o && !addr_wr_i && !rel_set_i) |=> scl_pull_o);

    assert_ua_raises_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr_o) |-> irq_o);

    assert_cmp_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q_o) |-> $past(addr_wr_i));

    assert_ack_while_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    assert_rel_clear_needs_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_o) |-> $past(stretch_en_i));

    assert_bf_cleared_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full_o) |-> $past(rxbuf_rd_i));

    assert_no_overflow_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> ($stable(rxbuf_o) && buf_full_o));
endmodule

bind i2c_tenbit_rx i2c_tenbit_rx_chk u_chk (.*);

// File: tb/tb_i2c_tenbit_rx.sv
module tb_i2c_tenbit_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_i, sda_i, scl_pull_o, sda_pull_o;
    logic addr_wr_i = 1'b0, rxbuf_rd_i = 1'b0, irq_clr_i = 1'b0, rel_set_i = 1'b0;
    logic stretch_en_i = 1'b0, start_irq_en_i = 1'b0;
    logic [7:0] addr_wdata_i = 8'h00;
    logic [7:0] addr_q_o, rxbuf_o;
    logic start_seen_o, upd_addr_o, buf_full_o, irq_o, ovf_o, rel_o;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    logic bf_prev = 1'b0;
    logic ack;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_i = m_scl & ~scl_pull_o;
    assign sda_i = m_sda & ~sda_pull_o;

    i2c_tenbit_rx dut (.*);

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each newly filled buffer against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && buf_full_o && !bf_prev) begin
            if (exp_q.size() == 0) check(1'b0, "R7 unexpected buffer load", rxbuf_o, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rxbuf_o == e, "R12 buffer content", rxbuf_o, e);
            end
        end
        bf_prev <= buf_full_o;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic sw_write(input logic [7:0] v);
        @(negedge clk) begin addr_wr_i = 1'b1; addr_wdata_i = v; end
        @(negedge clk) addr_wr_i = 1'b0;
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        while (scl_pull_o) @(negedge clk);
        cyc(1);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; cyc(HALF);
        scl_high(); cyc(HALF);
        m_sda = 1'b0; cyc(HALF);
        m_scl = 1'b0; cyc(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; cyc(HALF);
        scl_high(); cyc(HALF);
        m_sda = 1'b1; cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic mid_wr, input logic [7:0] mid_val,
                             output logic ack_o);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; cyc(HALF);
            scl_high(); cyc(HALF);
            m_scl = 1'b0;
            if (i == 4 && mid_wr) sw_write(mid_val);
        end
        m_sda = 1'b1; cyc(HALF);
        scl_high(); cyc(HALF/2);
        ack_o = sda_i;
        cyc(HALF/2);
        m_scl = 1'b0; cyc(HALF);
    endtask

    initial begin
        cyc(150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check(!scl_pull_o && !sda_pull_o && !buf_full_o && !irq_o && rel_o && !start_seen_o,
              "reset state", {scl_pull_o, sda_pull_o, buf_full_o, irq_o, rel_o}, 5'b00001);

        // R1: start without irq enable, then R10 stop clears start_seen
        bus_start();
        check(start_seen_o && !irq_o, "R1 start no irq", {start_seen_o, irq_o}, 2'b10);
        bus_stop(); cyc(4);
        check(!start_seen_o, "R10 stop clears start", start_seen_o, 0);

        // R1 with irq enabled
        sw_write(8'hF4);
        start_irq_en_i = 1'b1;
        bus_start();
        check(irq_o, "R1 start irq", irq_o, 1);
        pulse(irq_clr_i);

        // R2 high byte, with an ignored mid-byte write (R6)
        exp_q.push_back(8'hF4);
        send_byte(8'hF4, 1'b1, 8'h00, ack);
        check(ack == 1'b0, "R2 high ack", ack, 0);
        check(addr_q_o == 8'hF4, "R6 mid-byte write ignored", addr_q_o, 8'hF4);
        check(upd_addr_o && irq_o, "R2 ua irq", {upd_addr_o, irq_o}, 2'b11);
        check(scl_pull_o, "R3 scl held", scl_pull_o, 1);
        pulse(rxbuf_rd_i); pulse(irq_clr_i);
        check(!buf_full_o, "R9 read clears bf", buf_full_o, 0);
        sw_write(8'hA5);
        check(!scl_pull_o && !upd_addr_o, "R3 write releases", {scl_pull_o, upd_addr_o}, 0);

        // R4 low byte
        exp_q.push_back(8'hA5);
        send_byte(8'hA5, 1'b0, 8'h00, ack);
        check(ack == 1'b0 && upd_addr_o && irq_o, "R4 low match", {ack, upd_addr_o, irq_o}, 3'b011);
        pulse(rxbuf_rd_i); pulse(irq_clr_i);
        sw_write(8'hF4);

        // R7 data bytes
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, 1'b0, 8'h00, ack);
        check(ack == 1'b0 && buf_full_o && irq_o, "R7 data 3C", {ack, buf_full_o, irq_o}, 3'b011);
        pulse(rxbuf_rd_i); pulse(irq_clr_i);
        exp_q.push_back(8'hC3);
        send_byte(8'hC3, 1'b0, 8'h00, ack);
        check(ack == 1'b0, "R7 data C3 ack", ack, 0);
        pulse(rxbuf_rd_i); pulse(irq_clr_i);

        // R11 overflow
        exp_q.push_back(8'h55);
        send_byte(8'h55, 1'b0, 8'h00, ack);
        pulse(irq_clr_i);
        send_byte(8'h66, 1'b0, 8'h00, ack);
        check(ack == 1'b1, "R11 overflow nack", ack, 1);
        check(ovf_o && irq_o && rxbuf_o == 8'h55, "R11 ovf buffer kept", rxbuf_o, 8'h55);
        pulse(irq_clr_i);
        check(!ovf_o && !irq_o, "R11 irq_clr", {ovf_o, irq_o}, 0);
        pulse(rxbuf_rd_i);

        // R8 clock stretch on data
        stretch_en_i = 1'b1;
        exp_q.push_back(8'h81);
        send_byte(8'h81, 1'b0, 8'h00, ack);
        check(!rel_o && scl_pull_o, "R8 stretch hold", {rel_o, scl_pull_o}, 2'b01);
        pulse(rxbuf_rd_i);
        pulse(rel_set_i);
        check(rel_o && !scl_pull_o, "R8 release", {rel_o, scl_pull_o}, 2'b10);
        stretch_en_i = 1'b0;
        pulse(irq_clr_i);

        // R10 bytes after stop are ignored
        bus_stop(); cyc(4);
        send_byte(8'h77, 1'b0, 8'h00, ack);
        check(ack == 1'b1 && !buf_full_o, "R10 idle ignores", {ack, buf_full_o}, 2'b10);

        // R5 low mismatch
        bus_start();
        pulse(irq_clr_i);
        exp_q.push_back(8'hF4);
        send_byte(8'hF4, 1'b0, 8'h00, ack);
        pulse(rxbuf_rd_i); pulse(irq_clr_i);
        sw_write(8'hA5);
        send_byte(8'h11, 1'b0, 8'h00, ack);
        check(ack == 1'b1, "R5 low mismatch nack", ack, 1);
        check(upd_addr_o && irq_o && !buf_full_o && rel_o, "R5 flags",
              {upd_addr_o, irq_o, buf_full_o, rel_o}, 4'b1101);
        sw_write(8'hF4);
        pulse(irq_clr_i);
        send_byte(8'h22, 1'b0, 8'h00, ack);
        check(ack == 1'b1 && !buf_full_o, "R5 later bytes refused", {ack, buf_full_o}, 2'b10);
        bus_stop(); cyc(4);

        // R2 high mismatch (R/W set)
        bus_start();
        pulse(irq_clr_i);
        send_byte(8'hF5, 1'b0, 8'h00, ack);
        check(ack == 1'b1 && !upd_addr_o && !scl_pull_o && !irq_o, "R2 high mismatch",
              {ack, upd_addr_o, scl_pull_o, irq_o}, 4'b1000);
        bus_stop(); cyc(4);

        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule